// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds six 32-bit up-counters that a processor core uses to measure its own activity. Each counter has its own control register, which picks one of the incoming per-cycle event strobes and gates counting on the core's privilege level and on a process mark bit. A bank-wide control register can stop all counters at once. It also enables the interrupt request, and it can make the bank stop itself when an enabled counter overflows.

Software reaches every register through a plain register port. A write takes effect at the next clock edge, and a read is returned combinationally from the address. A counter is said to overflow when its top bit is set. To take a sample every N events, software loads a counter with 0x80000000 minus N, sets that counter's condition enable and the interrupt enable, and clears the bank freeze. The interrupt request is a level. It stays high until software reloads the counter below 0x80000000 or clears an enable. None of the pins is a data stream, so there is no valid/ready handshake and no back-pressure: a write is accepted on every cycle that `wr_en` is high.

Address map (`ADDR_W` = index width + 2, index in the low bits):
- kind 0: counter i is at address i.
- kind 1: control register i is at address 8+i.
- kind 2, index 0: the bank register is at address 16.

Control register fields, from bit 0 upward:
- bit 0: freeze always.
- bit 1: freeze in supervisor state.
- bit 2: freeze in user state.
- bit 3: freeze when mark=1.
- bit 4: freeze when mark=0.
- bit 5: condition enable.
- bits 11:8: event select.

Bank register fields: bit 0 is the bank freeze, bit 1 is the interrupt enable and bit 2 is freeze-on-overflow.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter and every control register reads 0, the bank register reads 0x1 (bank freeze set, both enables clear) and `irq` is low.
- R2: An unfrozen counter increases by exactly one on each clock edge at which the strobe chosen by its event select (bits 11:8) is high. A strobe it has not selected does not change it.
- R3: Each of the five freeze bits stops its counter while its condition holds: bit 0 always, bit 1 when `supervisor`=1, bit 2 when `supervisor`=0, bit 3 when `proc_mark`=1, and bit 4 when `proc_mark`=0. A freeze bit whose condition does not hold has no effect.
- R4: While the bank freeze (bank bit 0) is set, no counter changes except by a software write.
- R5: `irq` is high exactly when the interrupt enable (bank bit 1) is set and at least one counter has both its condition enable (bit 5) and its bit 31 set. It falls once that counter is rewritten below 0x80000000 or either enable is cleared.
- R6: With freeze-on-overflow (bank bit 2) set, no counter advances on any edge after a condition-enabled counter reaches bit 31 set, and the bank freeze bit reads 1 from the next cycle on. A software clear of the bank freeze in a cycle where that overflow is present is overridden. With bank bit 2 clear, an overflowed counter keeps counting.
- R7: A software write to a counter in the same cycle as an increment stores the written value.
- R8: Registers read back at the mapped addresses, with unused control bits 7:6 reading 0. Addresses outside the map read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_strobe | input | NUM_EV (16) | One strobe per selectable event, high for each cycle the event occurs |
| supervisor | input | 1 | 1 when the core is in supervisor state, 0 in user state |
| proc_mark | input | 1 | Process mark bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | CTR_W (32) | Write data |
| rd_addr | input | ADDR_W (5) | Read address |
| rd_data | output | CTR_W (32) | Combinational read data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that:
- no counter moves by more than one step unless it is written;
- a counter write lands exactly;
- a frozen bank keeps every counter still;
- an enabled overflow under freeze-on-overflow both sets the bank freeze and stops the counters at once;
- `irq` never rises without the interrupt enable and a live overflow.

Only the bench scenarios can show the rest. These are the meaning of each freeze condition for each privilege and mark value, the event selection, and the exact value at which the interrupt rises and clears. They also cover the hardware set of the freeze overriding a software clear, and the address map with its unmapped holes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DEF_NUM_CTR = 6;
  localparam int DEF_CTR_W   = 32;
  localparam int DEF_NUM_EV  = 16;

  // control register bit positions
  localparam int FZ_ALL = 0;
  localparam int FZ_SUP = 1;
  localparam int FZ_USR = 2;
  localparam int FZ_MK1 = 3;
  localparam int FZ_MK0 = 4;
  localparam int CND_EN = 5;
  localparam int EV_LSB = 8;

  // bank register bit positions
  localparam int G_FRZ = 0;
  localparam int G_IE  = 1;
  localparam int G_FOV = 2;
  localparam int G_W   = 3;

  // address kinds (top two address bits)
  localparam logic [1:0] KIND_CNT = 2'd0;
  localparam logic [1:0] KIND_CFG = 2'd1;
  localparam logic [1:0] KIND_GLB = 2'd2;

  function automatic int ev_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CTR_W  = DEF_CTR_W,
  parameter int NUM_EV = DEF_NUM_EV,
  localparam int EV_W  = ev_width(NUM_EV),
  localparam int CFG_W = EV_LSB + EV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cnt,
  input  logic              wr_cfg,
  input  logic [CTR_W-1:0]  wdata,
  input  logic [NUM_EV-1:0] ev,
  input  logic              supervisor,
  input  logic              proc_mark,
  input  logic              bank_freeze,
  output logic [CTR_W-1:0]  count,
  output logic [CFG_W-1:0]  cfg,
  output logic              ovf
);
  localparam logic [CFG_W-1:0] CFG_MASK = {{EV_W{1'b1}}, 2'b00, 6'h3F};

  logic [EV_W-1:0] sel;
  logic            ev_hit;
  logic            own_freeze;
  logic            inc;

  assign sel    = cfg[EV_LSB +: EV_W];
  assign ev_hit = (int'(sel) < NUM_EV) ? ev[sel] : 1'b0;

  always_comb begin
    own_freeze = cfg[FZ_ALL]
               | (cfg[FZ_SUP] &  supervisor)
               | (cfg[FZ_USR] & ~supervisor)
               | (cfg[FZ_MK1] &  proc_mark)
               | (cfg[FZ_MK0] & ~proc_mark);
  end

  assign inc = ev_hit & ~own_freeze & ~bank_freeze;
  assign ovf = cfg[CND_EN] & count[CTR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_cnt) begin
      count <= wdata;
    end else if (inc) begin
      count <= count + CTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_cfg) begin
      cfg <= wdata[CFG_W-1:0] & CFG_MASK;
    end
  end
endmodule

// File: rtl/pmc_global.sv
module pmc_global
  import pmc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [G_W-1:0] wdata,
  input  logic           ovf_any,
  output logic [G_W-1:0] glob_q,
  output logic           bank_freeze,
  output logic           irq
);
  logic hw_freeze;

  // an enabled overflow stops counting in the very cycle it appears
  assign hw_freeze   = glob_q[G_FOV] & ovf_any;
  assign bank_freeze = glob_q[G_FRZ] | hw_freeze;
  assign irq         = glob_q[G_IE] & ovf_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= G_W'(1 << G_FRZ);
    end else begin
      if (wr) begin
        glob_q <= wdata;
      end
      if (hw_freeze) begin
        glob_q[G_FRZ] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmc_readmux.sv
module pmc_readmux
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = DEF_NUM_CTR,
  parameter int CTR_W   = DEF_CTR_W,
  parameter int CFG_W   = 12,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_CTR-1:0][CTR_W-1:0]   cnt_bus,
  input  logic [NUM_CTR-1:0][CFG_W-1:0]   cfg_bus,
  input  logic [G_W-1:0]                  glob_q,
  output logic [CTR_W-1:0]                rdata
);
  logic [1:0]       kind;
  logic [IDX_W-1:0] idx;

  assign kind = addr[ADDR_W-1 -: 2];
  assign idx  = addr[IDX_W-1:0];

  always_comb begin
    rdata = '0;
    case (kind)
      KIND_CNT: begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (idx == IDX_W'(i)) rdata = cnt_bus[i];
        end
      end
      KIND_CFG: begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (idx == IDX_W'(i)) rdata = CTR_W'(cfg_bus[i]);
        end
      end
      KIND_GLB: begin
        if (idx == '0) rdata = CTR_W'(glob_q);
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = DEF_NUM_CTR,
  parameter int CTR_W   = DEF_CTR_W,
  parameter int NUM_EV  = DEF_NUM_EV,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int ADDR_W = IDX_W + 2,
  localparam int EV_W   = ev_width(NUM_EV),
  localparam int CFG_W  = EV_LSB + EV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] event_strobe,
  input  logic              supervisor,
  input  logic              proc_mark,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTR_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CTR_W-1:0]  rd_data,
  output logic              irq
);
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_bus;
  logic [NUM_CTR-1:0][CFG_W-1:0] cfg_bus;
  logic [NUM_CTR-1:0]            ovf_vec;
  logic [G_W-1:0]                glob_q;
  logic                          bank_freeze;
  logic [1:0]                    wr_kind;
  logic [IDX_W-1:0]              wr_idx;

  assign wr_kind = wr_addr[ADDR_W-1 -: 2];
  assign wr_idx  = wr_addr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    pmc_counter #(
      .CTR_W  (CTR_W),
      .NUM_EV (NUM_EV)
    ) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_cnt      (wr_en && wr_kind == KIND_CNT && wr_idx == IDX_W'(i)),
      .wr_cfg      (wr_en && wr_kind == KIND_CFG && wr_idx == IDX_W'(i)),
      .wdata       (wr_data),
      .ev          (event_strobe),
      .supervisor  (supervisor),
      .proc_mark   (proc_mark),
      .bank_freeze (bank_freeze),
      .count       (cnt_bus[i]),
      .cfg         (cfg_bus[i]),
      .ovf         (ovf_vec[i])
    );
  end

  pmc_global u_glob (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr_en && wr_kind == KIND_GLB && wr_idx == '0),
    .wdata       (wr_data[G_W-1:0]),
    .ovf_any     (|ovf_vec),
    .glob_q      (glob_q),
    .bank_freeze (bank_freeze),
    .irq         (irq)
  );

  pmc_readmux #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .CFG_W   (CFG_W)
  ) u_rd (
    .addr    (rd_addr),
    .cnt_bus (cnt_bus),
    .cfg_bus (cfg_bus),
    .glob_q  (glob_q),
    .rdata   (rd_data)
  );
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = DEF_NUM_CTR,
  parameter int CTR_W   = DEF_CTR_W,
  parameter int ADDR_W  = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [CTR_W-1:0]              wr_data,
  input logic                          irq,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_bus,
  input logic [NUM_CTR-1:0]            ovf_vec,
  input logic [G_W-1:0]                glob_q
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_c
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(i)) |=>
        (cnt_bus[i] == $past(cnt_bus[i]) ||
         cnt_bus[i] == $past(cnt_bus[i]) + CTR_W'(1)));

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i)) |=> cnt_bus[i] == $past(wr_data));
  end

  assert_bank_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_q[G_FRZ] && !wr_en) |=> $stable(cnt_bus));

  assert_ovf_sets_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_q[G_FOV] && |ovf_vec) |=> glob_q[G_FRZ]);

  assert_ovf_stops_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_q[G_FOV] && |ovf_vec && !wr_en) |=> $stable(cnt_bus));

  assert_irq_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q[G_IE] |-> !irq);

  assert_irq_needs_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |ovf_vec);
endmodule

bind pmc_bank pmc_bank_chk #(
  .NUM_CTR (NUM_CTR),
  .CTR_W   (CTR_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .irq     (irq),
  .cnt_bus (cnt_bus),
  .ovf_vec (ovf_vec),
  .glob_q  (glob_q)
);

// File: tb/tb_pmc_bank.sv
module tb_pmc_bank;
  localparam int NV = 11;
  // {freeze bits[4:0], supervisor, mark, strobed line[3:0], expected count[4:0]}; select is always 3
  localparam logic [15:0] VEC [0:NV-1] = '{
    {5'b00000, 1'b0, 1'b0, 4'd3, 5'd4},
    {5'b00001, 1'b0, 1'b0, 4'd3, 5'd0},
    {5'b00010, 1'b1, 1'b0, 4'd3, 5'd0},
    {5'b00010, 1'b0, 1'b0, 4'd3, 5'd4},
    {5'b00100, 1'b0, 1'b0, 4'd3, 5'd0},
    {5'b00100, 1'b1, 1'b0, 4'd3, 5'd4},
    {5'b01000, 1'b0, 1'b1, 4'd3, 5'd0},
    {5'b01000, 1'b0, 1'b0, 4'd3, 5'd4},
    {5'b10000, 1'b0, 1'b0, 4'd3, 5'd0},
    {5'b10000, 1'b0, 1'b1, 4'd3, 5'd4},
    {5'b00000, 1'b0, 1'b0, 4'd5, 5'd0}
  };
  localparam logic [4:0] GLB = 5'd16;
  localparam logic [31:0] CE = 32'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] event_strobe = '0;
  logic        supervisor = 1'b0;
  logic        proc_mark = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmc_bank dut (
    .clk(clk), .rst_n(rst_n), .event_strobe(event_strobe),
    .supervisor(supervisor), .proc_mark(proc_mark),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic strobe(input int line, input int n);
    @(negedge clk);
    event_strobe = 16'(1 << line);
    repeat (n) @(negedge clk);
    event_strobe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(5'(i), v); chk("R1 counter", v, 32'h0);
      rd(5'(8 + i), v); chk("R1 control", v, 32'h0);
    end
    rd(GLB, v); chk("R1 bank reg", v, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R4 bank freeze from reset holds counter 0 (select 0, no own freeze)
    strobe(0, 3);
    rd(5'd0, v); chk("R4 frozen after reset", v, 32'h0);
    wr(GLB, 32'h0);

    // R2 / R3 vector walk on counter 0
    for (int k = 0; k < NV; k++) begin
      wr(5'd0, 32'h0);
      wr(5'd8, {27'b0, VEC[k][15:11]} | (32'd3 << 8));
      supervisor = VEC[k][10];
      proc_mark  = VEC[k][9];
      strobe(int'(VEC[k][8:5]), 4);
      rd(5'd0, v);
      chk($sformatf("R2 R3 vector %0d", k), v, {27'b0, VEC[k][4:0]});
    end
    supervisor = 1'b0; proc_mark = 1'b0;

    // R4 bank freeze set by software
    wr(5'd0, 32'h0);
    wr(GLB, 32'h1);
    strobe(3, 4);
    rd(5'd0, v); chk("R4 software freeze", v, 32'h0);
    wr(GLB, 32'h0);

    // R7 write wins over simultaneous increment
    @(negedge clk);
    event_strobe = 16'h0008; wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h1234;
    @(negedge clk);
    wr_en = 1'b0; event_strobe = '0;
    rd(5'd0, v); chk("R7 write beats count", v, 32'h1234);
    strobe(3, 1);
    rd(5'd0, v); chk("R7 counting after write", v, 32'h1235);

    // R5 interrupt rises exactly at bit 31
    wr(5'd1, 32'h7FFF_FFFE);
    wr(5'd9, CE | (32'd2 << 8));
    wr(GLB, 32'h2);
    chk("R5 irq low below msb", {31'b0, irq}, 32'h0);
    strobe(2, 1);
    rd(5'd1, v); chk("R5 count 7fffffff", v, 32'h7FFF_FFFF);
    chk("R5 irq still low", {31'b0, irq}, 32'h0);
    strobe(2, 1);
    rd(5'd1, v); chk("R5 count 80000000", v, 32'h8000_0000);
    chk("R5 irq high at overflow", {31'b0, irq}, 32'h1);
    strobe(2, 2);
    rd(5'd1, v); chk("R6 counts past overflow when bit 2 clear", v, 32'h8000_0002);
    chk("R5 irq level held", {31'b0, irq}, 32'h1);
    wr(5'd1, 32'h5);
    chk("R5 irq clears on reload", {31'b0, irq}, 32'h0);

    // R5 condition enable and interrupt enable gating
    wr(5'd2, 32'h8000_0000);
    chk("R5 no irq without condition enable", {31'b0, irq}, 32'h0);
    wr(5'd10, CE);
    chk("R5 irq with condition enable", {31'b0, irq}, 32'h1);
    wr(GLB, 32'h0);
    chk("R5 irq off without interrupt enable", {31'b0, irq}, 32'h0);
    wr(5'd10, 32'h0);
    wr(5'd2, 32'h0);

    // R6 freeze on overflow
    wr(5'd0, 32'd100);
    wr(5'd8, 32'd2 << 8);
    wr(5'd1, 32'h7FFF_FFFF);
    wr(GLB, 32'h6);
    strobe(2, 3);
    rd(5'd0, v); chk("R6 neighbour stops", v, 32'd101);
    rd(5'd1, v); chk("R6 overflowed stops", v, 32'h8000_0000);
    rd(GLB, v); chk("R6 freeze bit set", v, 32'h7);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    wr(GLB, 32'h6);
    rd(GLB, v); chk("R6 hw set beats sw clear", v, 32'h7);
    wr(5'd1, 32'h0);
    chk("R6 irq low after reload", {31'b0, irq}, 32'h0);
    wr(GLB, 32'h6);
    rd(GLB, v); chk("R6 freeze cleared", v, 32'h6);
    strobe(2, 2);
    rd(5'd0, v); chk("R6 resumes", v, 32'd103);
    rd(5'd1, v); chk("R6 overflowed resumes", v, 32'd2);

    // R8 address map
    rd(5'd9, v); chk("R8 control readback", v, CE | (32'd2 << 8));
    wr(5'd8, 32'hFFFF_FFFF);
    rd(5'd8, v); chk("R8 reserved control bits", v, 32'h0000_0F3F);
    wr(5'd8, 32'd2 << 8);
    wr(5'd6, 32'hDEAD);
    rd(5'd6, v); chk("R8 hole reads zero", v, 32'h0);
    wr(5'd17, 32'h1);
    rd(GLB, v); chk("R8 hole write ignored", v, 32'h6);
    rd(5'd0, v); chk("R8 counter untouched", v, 32'd103);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule